// File: doc/BRIEF.md
# Quadrature-Capable Edge Counter

This block keeps one signed tally driven by edges on two input channels. Each channel has a pulse line and a steering line. For each polarity of the pulse line, the channel can add one to the tally, subtract one, or leave it alone. The steering line can pass that choice through, block it, or reverse its sign. If the two pulse lines carry quadrature signals, they can be configured so that the tally follows position, including direction.

All four inputs are first brought into the clock domain by a two-stage synchroniser. Each then passes an optional debounce stage, which accepts a new level only after the level has held for a programmable number of clock cycles. A synchronous clear resets the tally. The tally is always visible on an output.

Top module: `quad_edge_counter`

## Requirements
- R1: After reset, `count` reads 0.
- R2: When `clr` is high at a clock edge, `count` is 0 after that edge. This applies even if a counting edge is due in the same cycle, and that edge is then lost.
- R3: Each channel has a 2-bit action code for each polarity, `rise_act` and `fall_act` (channel 0 in bits [1:0], channel 1 in bits [3:2]). The codes are: 0 = no change, 1 = add one, 2 = subtract one, 3 = no change.
- R4: Rising and falling edges are chosen separately through their own codes. Setting both to count makes every transition count.
- R5: A per-channel 2-bit `ctl_mode` (same bit layout as R3) decides how the synchronised steering level acts: 0 = steering ignored, 1 = no change while steering is low, 2 = sign reversed while steering is low, 3 = no change while steering is high.
- R6: If both channels produce an action in the same cycle, their sum is applied in one step, so `count` moves by at most 2 per cycle.
- R7: `count` is 16-bit two's complement and wraps: one past +32767 gives -32768, and one below -32768 gives +32767.
- R8: With `flt_en` high, a level on any input is accepted only after it has held for `flt_thr` consecutive cycles. Shorter pulses are discarded. A threshold of 0 acts as 1.
- R9: With the filter off or the threshold at 1, an input change shows in `count` after exactly four rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous tally clear |
| sig_in | input | 2 | Pulse lines, bit n belongs to channel n |
| ctl_in | input | 2 | Steering lines, bit n belongs to channel n |
| rise_act | input | 4 | Rising-edge action codes, 2 bits per channel |
| fall_act | input | 4 | Falling-edge action codes, 2 bits per channel |
| ctl_mode | input | 4 | Steering modes, 2 bits per channel |
| flt_en | input | 1 | Debounce enable for all inputs |
| flt_thr | input | 10 | Debounce hold length in cycles |
| count | output | 16 | Signed tally |

## Verification
Two pairs of events can fall in the same cycle: edges on both channels, and a clear together with an edge that is due. For the first pair, the bench toggles both pulse lines on the same clock, with equal and with opposite actions. It then samples `count` on the single cycle where the step lands and expects a jump of +2 or a net of 0. For the second pair, the bench raises `clr` on the exact cycle the tally would move and expects 0 on that cycle and on the next. The random phase changes both channels together at every step and compares each result with a model held in the bench.

// File: rtl/qec_pkg.sv
package qec_pkg;

  localparam int NUM_CH = 2;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_INC   = 2'd1,
    ACT_DEC   = 2'd2,
    ACT_HOLD3 = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    CTL_IGNORE    = 2'd0,
    CTL_GATE_LO   = 2'd1,
    CTL_INVERT_LO = 2'd2,
    CTL_GATE_HI   = 2'd3
  } ctl_mode_e;

  // Map an action code to a unit step.
  function automatic logic signed [1:0] code_to_delta(input logic [1:0] code);
    case (act_e'(code))
      ACT_INC: return 2'sb01;
      ACT_DEC: return 2'sb11;
      default: return 2'sb00;
    endcase
  endfunction

  // Apply the steering-line policy to a unit step.
  function automatic logic signed [1:0] steer(input logic signed [1:0] d,
                                              input logic [1:0] mode,
                                              input logic ctl);
    case (ctl_mode_e'(mode))
      CTL_GATE_LO:   return ctl ? d : 2'sb00;
      CTL_INVERT_LO: return ctl ? d : -d;
      CTL_GATE_HI:   return ctl ? 2'sb00 : d;
      default:       return d;
    endcase
  endfunction

  // Net of two unit steps, range -2..+2.
  function automatic logic signed [2:0] net_step(input logic signed [1:0] a,
                                                 input logic signed [1:0] b);
    return {a[1], a} + {b[1], b};
  endfunction

endpackage

// File: rtl/qec_sync_filter.sv
module qec_sync_filter #(
  parameter int FLT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic             flt_en,
  input  logic [FLT_W-1:0] thr,
  output logic             dout
);

  logic             s1_q, s2_q, f_q;
  logic [FLT_W-1:0] run_q;
  logic [FLT_W-1:0] thr_eff;
  logic             held_long;

  assign thr_eff   = (thr == '0) ? FLT_W'(1) : thr;
  assign held_long = ({1'b0, run_q} + 1'b1) >= {1'b0, thr_eff};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_q   <= 1'b0;
      run_q <= '0;
    end else if (!flt_en) begin
      f_q   <= s2_q;
      run_q <= '0;
    end else if (s2_q == f_q) begin
      run_q <= '0;
    end else if (held_long) begin
      f_q   <= s2_q;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign dout = f_q;

endmodule

// File: rtl/qec_channel.sv
module qec_channel
  import qec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sig_f,
  input  logic              ctl_f,
  input  logic [1:0]        rise_code,
  input  logic [1:0]        fall_code,
  input  logic [1:0]        mode,
  output logic              rise_ev,
  output logic              fall_ev,
  output logic signed [1:0] delta
);

  logic sig_d_q;
  logic signed [1:0] raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_d_q <= 1'b0;
    else        sig_d_q <= sig_f;
  end

  assign rise_ev = sig_f & ~sig_d_q;
  assign fall_ev = ~sig_f & sig_d_q;

  always_comb begin
    if (rise_ev)      raw = code_to_delta(rise_code);
    else if (fall_ev) raw = code_to_delta(fall_code);
    else              raw = 2'sb00;
  end

  assign delta = steer(raw, mode, ctl_f);

endmodule

// File: rtl/quad_edge_counter.sv
module quad_edge_counter
  import qec_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int FLT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [1:0]       sig_in,
  input  logic [1:0]       ctl_in,
  input  logic [3:0]       rise_act,
  input  logic [3:0]       fall_act,
  input  logic [3:0]       ctl_mode,
  input  logic             flt_en,
  input  logic [FLT_W-1:0] flt_thr,
  output logic [CNT_W-1:0] count
);

  localparam int EXT_W = CNT_W - 3;

  logic [NUM_CH-1:0]   sig_f;
  logic [NUM_CH-1:0]   ctl_f;
  logic [NUM_CH-1:0]   rise_ev;
  logic [NUM_CH-1:0]   fall_ev;
  logic [2*NUM_CH-1:0] ch_delta;
  logic signed [2:0]   step;
  logic [CNT_W-1:0]    count_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic signed [1:0] d;

    qec_sync_filter #(.FLT_W(FLT_W)) u_sig_flt (
      .clk(clk), .rst_n(rst_n), .din(sig_in[c]),
      .flt_en(flt_en), .thr(flt_thr), .dout(sig_f[c])
    );

    qec_sync_filter #(.FLT_W(FLT_W)) u_ctl_flt (
      .clk(clk), .rst_n(rst_n), .din(ctl_in[c]),
      .flt_en(flt_en), .thr(flt_thr), .dout(ctl_f[c])
    );

    qec_channel u_ch (
      .clk(clk), .rst_n(rst_n),
      .sig_f(sig_f[c]), .ctl_f(ctl_f[c]),
      .rise_code(rise_act[2*c +: 2]),
      .fall_code(fall_act[2*c +: 2]),
      .mode(ctl_mode[2*c +: 2]),
      .rise_ev(rise_ev[c]), .fall_ev(fall_ev[c]),
      .delta(d)
    );

    assign ch_delta[2*c +: 2] = d;
  end

  assign step = net_step(signed'(ch_delta[1:0]), signed'(ch_delta[3:2]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count_q <= '0;
    else if (clr) count_q <= '0;
    else          count_q <= count_q + {{EXT_W{step[2]}}, step};
  end

  assign count = count_q;

endmodule

// File: rtl/qec_checker.sv
module qec_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        clr,
  input logic [15:0] count,
  input logic [1:0]  rise_ev,
  input logic [1:0]  fall_ev,
  input logic [3:0]  ch_delta,
  input logic [3:0]  rise_act,
  input logic [3:0]  ctl_mode,
  input logic [1:0]  ctl_f
);

  // R1
  reset_val_chk: assert property (@(posedge clk) !rst_n |=> count == 16'h0000);

  // R2
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == 16'h0000);

  // R6
  net_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((count - $past(count)) inside {16'h0000, 16'h0001, 16'h0002,
                                             16'hFFFF, 16'hFFFE}));

  // R4
  one_edge0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_ev[0], fall_ev[0]}));

  // R4
  one_edge1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_ev[1], fall_ev[1]}));

  // R3
  hold_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_ev[0] && (rise_act[1:0] == 2'd0 || rise_act[1:0] == 2'd3))
      |-> ch_delta[1:0] == 2'b00);

  // R5
  gate_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_mode[3:2] == 2'd1 && !ctl_f[1]) |-> ch_delta[3:2] == 2'b00);

endmodule

bind quad_edge_counter qec_checker chk_i (
  .clk(clk), .rst_n(rst_n), .clr(clr), .count(count),
  .rise_ev(rise_ev), .fall_ev(fall_ev), .ch_delta(ch_delta),
  .rise_act(rise_act), .ctl_mode(ctl_mode), .ctl_f(ctl_f)
);

// File: tb/quad_edge_counter_tb.sv
module quad_edge_counter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic [1:0]  sig_in = 2'b00;
  logic [1:0]  ctl_in = 2'b00;
  logic [3:0]  rise_act = 4'h0;
  logic [3:0]  fall_act = 4'h0;
  logic [3:0]  ctl_mode = 4'h0;
  logic        flt_en = 1'b0;
  logic [9:0]  flt_thr = 10'd1;
  logic [15:0] count;

  int total = 0;
  int bad = 0;
  int model = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  quad_edge_counter dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .sig_in(sig_in), .ctl_in(ctl_in),
    .rise_act(rise_act), .fall_act(fall_act), .ctl_mode(ctl_mode),
    .flt_en(flt_en), .flt_thr(flt_thr), .count(count)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int cnt_now();
    return int'($signed(count));
  endfunction

  function automatic int wrap16(input int v);
    return ((v + 32768 + 65536 * 4) % 65536) - 32768;
  endfunction

  function automatic int unit_of(input bit r, input bit f, input bit [1:0] ra,
                                 input bit [1:0] fa, input bit [1:0] md, input bit ctl);
    int d;
    bit [1:0] code;
    code = r ? ra : (f ? fa : 2'd0);
    d = (code == 2'd1) ? 1 : ((code == 2'd2) ? -1 : 0);
    if (md == 2'd1 && !ctl) d = 0;
    if (md == 2'd2 && !ctl) d = -d;
    if (md == 2'd3 && ctl)  d = 0;
    return d;
  endfunction

  task automatic do_clear();
    clr = 1'b1; tick(1); clr = 1'b0; model = 0;
  endtask

  // Move to new input levels, update the model and wait for the result.
  task automatic apply(input bit [1:0] ns, input bit [1:0] nc, input int wait_n);
    for (int c = 0; c < 2; c++) begin
      bit r, f;
      r = ns[c] & ~sig_in[c];
      f = ~ns[c] & sig_in[c];
      model += unit_of(r, f, rise_act[2*c +: 2], fall_act[2*c +: 2],
                       ctl_mode[2*c +: 2], nc[c]);
    end
    model = wrap16(model);
    sig_in = ns; ctl_in = nc;
    tick(wait_n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    tick(3);
    check("R1 reset", cnt_now(), 0);
    rst_n = 1'b1;
    tick(2);
    check("R1 after release", cnt_now(), 0);

    // R9 latency: ch0 counts up on rise
    rise_act = 4'b0001;
    sig_in = 2'b01;
    tick(3);
    check("R9 before 4th edge", cnt_now(), 0);
    tick(1);
    check("R9 at 4th edge", cnt_now(), 1);
    sig_in = 2'b00; tick(8);
    check("R4 fall ignored with hold code", cnt_now(), 1);

    // R2 clear colliding with a due edge
    sig_in = 2'b01; tick(3);
    clr = 1'b1; tick(1);
    check("R2 clear wins", cnt_now(), 0);
    clr = 1'b0; tick(1);
    check("R2 edge lost", cnt_now(), 0);
    sig_in = 2'b00; tick(8); model = 0;

    // R3 each action code on rise of channel 0
    for (int code = 0; code < 4; code++) begin
      do_clear();
      rise_act = 4'(code); fall_act = 4'h0;
      apply(2'b01, 2'b00, 8);
      apply(2'b00, 2'b00, 8);
      check($sformatf("R3 code %0d", code), cnt_now(), (code == 1) ? 1 : ((code == 2) ? -1 : 0));
    end

    // R4 both polarities count
    do_clear();
    rise_act = 4'b0001; fall_act = 4'b0001;
    apply(2'b01, 2'b00, 8);
    apply(2'b00, 2'b00, 8);
    check("R4 both polarities", cnt_now(), 2);

    // R5 steering modes, ch0 rise = add one
    for (int md = 0; md < 4; md++) begin
      for (int lvl = 0; lvl < 2; lvl++) begin
        int exp;
        do_clear();
        rise_act = 4'b0001; fall_act = 4'h0; ctl_mode = 4'(md);
        apply(2'b00, 2'(lvl), 8);
        apply(2'b01, 2'(lvl), 8);
        apply(2'b00, 2'(lvl), 8);
        exp = (md == 1) ? lvl : ((md == 2) ? (lvl ? 1 : -1) : ((md == 3) ? 1 - lvl : 1));
        check($sformatf("R5 mode %0d ctl %0d", md, lvl), cnt_now(), exp);
      end
    end
    ctl_mode = 4'h0; ctl_in = 2'b00;

    // R6 both channels in one cycle
    do_clear();
    rise_act = 4'b0101; fall_act = 4'h0;
    sig_in = 2'b11; tick(3);
    check("R6 not yet", cnt_now(), 0);
    tick(1);
    check("R6 jump of two in one cycle", cnt_now(), 2);
    sig_in = 2'b00; tick(8);
    rise_act = 4'b1001;
    sig_in = 2'b11; tick(8);
    check("R6 opposite actions cancel", cnt_now(), 2);
    sig_in = 2'b00; tick(8);

    // R8 debounce
    do_clear();
    rise_act = 4'b0001; fall_act = 4'h0;
    flt_en = 1'b1; flt_thr = 10'd5;
    sig_in = 2'b01; tick(4); sig_in = 2'b00; tick(16);
    check("R8 short pulse dropped", cnt_now(), 0);
    sig_in = 2'b01; tick(5); sig_in = 2'b00; tick(16);
    check("R8 pulse at threshold counts", cnt_now(), 1);
    flt_thr = 10'd0;
    sig_in = 2'b01; tick(1); sig_in = 2'b00; tick(10);
    check("R8 zero threshold acts as one", cnt_now(), 2);
    flt_en = 1'b0; flt_thr = 10'd1;

    // R7 wrap upward then downward
    do_clear();
    rise_act = 4'b0101; fall_act = 4'b0101;
    for (int i = 0; i < 16384; i++) begin
      sig_in = ~sig_in; tick(1);
    end
    tick(6);
    check("R7 wrap past max", cnt_now(), -32768);
    rise_act = 4'b1010; fall_act = 4'b1010;
    sig_in = 2'b11; tick(8);
    check("R7 wrap past min", cnt_now(), 32766);
    sig_in = 2'b00; tick(8);

    // Random phase, both channels change together
    do_clear();
    model = 0;
    for (int blk = 0; blk < 15; blk++) begin
      int thr_e;
      rise_act = 4'($urandom); fall_act = 4'($urandom); ctl_mode = 4'($urandom);
      flt_en = 1'($urandom); flt_thr = 10'($urandom_range(0, 6));
      thr_e = (flt_en && flt_thr > 0) ? int'(flt_thr) : 1;
      for (int s = 0; s < 20; s++) begin
        apply(2'($urandom), 2'($urandom), thr_e + 8);
        check("R6 random net step", cnt_now(), model);
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule